// File: doc/BRIEF.md
# Host interface pad shutdown controller

This block sits between a host-interface peripheral and the shared I/O pads it uses. It decides, for each shared pad, whether register settings have given it the host function. It then gates the pad's output enable, and conditions the input the peripheral receives from it. An active-low shutdown pad can isolate the whole host interface. While that pad is held low, and shutdown is permitted, every host-selected output pad is released to high impedance. Every host-selected input is also held at logic high inside the chip.

An input that shares a pad with a host function is held high as well while that pad is isolated. Examples are a timer clock, a timer reset and a trigger input. Pads that are not in the host function keep working as ordinary pads. The shutdown pad passes through a two-flop synchronizer and then two more qualification flops before it takes effect. Release takes the same path. Output data values pass through unchanged. Only the enables are gated.

Top module: `hsd_top`

## Requirements
- R1: Slave mode is `cfg_single_chip & cfg_host_en`. Shutdown takes effect only when slave mode holds and `cfg_sd_en`=1. Otherwise `sd_pad_n` has no effect on any output, however long it stays low.
- R2: A low level on `sd_pad_n` becomes active shutdown after exactly four rising clock edges. It has no effect after three. This is two synchronizer flops plus two qualification flops.
- R3: Bit order of `hp_out_*`/`pad_out_*` is 0=interrupt 1, 1=interrupt 11, 2=interrupt 12, 3=gate-A20. `cfg_dir` bit order is 0=interrupt 1, 1=interrupt 11, 2=interrupt 12. The selection conditions are:
  - bit 0 is selected when slave mode and `cfg_dir[0]` both hold;
  - bit 1 is selected when slave mode, `cfg_cs2_en` and `cfg_dir[1]` all hold;
  - bit 2 is selected when slave mode and `cfg_dir[2]` both hold;
  - bit 3 is selected when slave mode and `cfg_ga20_en` both hold.
  `pad_out_oe[i]` = selected AND `hp_out_oe[i]` AND NOT shutdown.
- R4: `pad_db_oe` is all ones exactly when slave mode holds, `hp_db_oe`=1 and there is no shutdown. Otherwise it is all zeros.
- R5: During shutdown, these inputs are driven high whatever the pad levels are: `hp_cs1_n`, `hp_rd_n`, `hp_wr_n`, `hp_a0` and all bits of `hp_db_i`. Outside shutdown they follow their pads.
- R6: `hp_cs2_n` selects its source as follows:
  - it comes from `pad_cs2a_n` when `cfg_cs2_en`=1 and `cfg_ga20_en`=0;
  - it comes from `pad_shared_i[2]` when `cfg_cs2_en`=1 and `cfg_ga20_en`=1;
  - it is 1 when `cfg_cs2_en`=0;
  - it is forced to 1 during shutdown when a source is selected.
- R7: `alt_in_o[k]` follows `pad_shared_i[k]`, except that it is forced to 1 when that pad is host-selected and shutdown is active. Pad 0 is host-selected per R3 bit 1 and pad 1 per R3 bit 2. Pad 2 is host-selected when slave mode, `cfg_cs2_en` and `cfg_ga20_en` all hold.
- R8: `pad_out_o` equals `hp_out_o` and `pad_db_o` equals `hp_db_o` at all times.
- R9: After reset with `sd_pad_n` high, shutdown is inactive.
- R10: A high level on `sd_pad_n` ends shutdown after exactly four rising edges. All affected pads then resume normal behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_single_chip | input | 1 | Device is in single-chip mode |
| cfg_host_en | input | 1 | Host interface enable |
| cfg_sd_en | input | 1 | Shutdown-pad enable |
| cfg_cs2_en | input | 1 | Second chip select enable |
| cfg_ga20_en | input | 1 | Gate-A20 output enable |
| cfg_dir | input | 3 | Port direction bits for the interrupt pads |
| sd_pad_n | input | 1 | Asynchronous active-low shutdown pad |
| hp_out_o | input | 4 | Peripheral output values |
| hp_out_oe | input | 4 | Peripheral drive requests |
| hp_db_o | input | 8 | Peripheral data-bus output value |
| hp_db_oe | input | 1 | Peripheral data-bus drive request |
| pad_out_oe | output | 4 | Output enables to the output pads |
| pad_out_o | output | 4 | Output values to the output pads |
| pad_db_oe | output | 8 | Data-bus pad output enables |
| pad_db_o | output | 8 | Data-bus pad output values |
| pad_cs1_n | input | 1 | First chip-select pad level |
| pad_cs2a_n | input | 1 | Second chip select on the pad shared with gate-A20 |
| pad_rd_n | input | 1 | Read strobe pad level |
| pad_wr_n | input | 1 | Write strobe pad level |
| pad_a0 | input | 1 | Address-bit pad level |
| pad_db_i | input | 8 | Data-bus pad levels |
| pad_shared_i | input | 3 | Levels of the interrupt-11 pad, the interrupt-12 pad and the alternate second chip-select pad |
| hp_cs1_n | output | 1 | Conditioned first chip select |
| hp_cs2_n | output | 1 | Conditioned second chip select |
| hp_rd_n | output | 1 | Conditioned read strobe |
| hp_wr_n | output | 1 | Conditioned write strobe |
| hp_a0 | output | 1 | Conditioned address bit |
| hp_db_i | output | 8 | Conditioned data-bus input |
| alt_in_o | output | 3 | Conditioned alternate-function inputs of the shared pads |

## Verification
The bench counts clock edges after each shutdown-pad transition. A pipeline one stage short or one stage long would switch the enables a cycle early or late. The bench also walks the chip-select and gate-A20 combinations. A design that swapped the two second chip-select sources, or shut down a pad with no host function, would force the wrong input high or leave a timer input frozen. It holds the shutdown pad low with the shutdown enable off and with slave mode off, and checks that nothing changes. Finally it runs shutdown with partial drive requests, to catch an enable that ignores the peripheral's own request.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    localparam int NUM_OUT = 4;
    localparam int NUM_ALT = 3;
    localparam int NUM_DIR = 3;

    typedef enum int {
        OUT_IRQ1  = 0,
        OUT_IRQ11 = 1,
        OUT_IRQ12 = 2,
        OUT_GA20  = 3
    } out_idx_e;

    typedef enum int {
        ALT_IRQ11_PAD = 0,
        ALT_IRQ12_PAD = 1,
        ALT_CS2B_PAD  = 2
    } alt_idx_e;

    typedef struct packed {
        logic               single_chip;
        logic               host_en;
        logic               sd_en;
        logic               cs2_en;
        logic               ga20_en;
        logic [NUM_DIR-1:0] dir;
    } hsd_cfg_t;

    typedef struct packed {
        logic               slave;
        logic               sd_allowed;
        logic [NUM_OUT-1:0] out_sel;
        logic [NUM_ALT-1:0] alt_sel;
        logic               cs2a_sel;
        logic               cs2b_sel;
    } hsd_sel_t;

    typedef struct packed {
        logic cs1_n;
        logic rd_n;
        logic wr_n;
        logic a0;
    } hsd_ctl_t;

    function automatic logic hold_high(input logic sel, input logic sd, input logic lvl);
        return (sel & sd) | lvl;
    endfunction

endpackage

// File: rtl/hsd_sync.sv
module hsd_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pad_n,
    output logic low_q
);
    localparam int TOTAL = SYNC_STAGES + HOLD_STAGES;

    logic [TOTAL-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[TOTAL-2:0], pad_n};
    end

    assign low_q = ~chain_q[TOTAL-1];
endmodule

// File: rtl/hsd_select.sv
module hsd_select
    import hsd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hsd_cfg_t cfg,
    output hsd_sel_t sel
);
    always_comb begin
        sel.slave      = cfg.single_chip & cfg.host_en;
        sel.sd_allowed = sel.slave & cfg.sd_en;
        sel.out_sel[OUT_IRQ1]  = sel.slave & cfg.dir[0];
        sel.out_sel[OUT_IRQ11] = sel.slave & cfg.cs2_en & cfg.dir[1];
        sel.out_sel[OUT_IRQ12] = sel.slave & cfg.dir[2];
        sel.out_sel[OUT_GA20]  = sel.slave & cfg.ga20_en;
        sel.cs2a_sel = cfg.cs2_en & ~cfg.ga20_en;
        sel.cs2b_sel = cfg.cs2_en & cfg.ga20_en;
        sel.alt_sel[ALT_IRQ11_PAD] = sel.out_sel[OUT_IRQ11];
        sel.alt_sel[ALT_IRQ12_PAD] = sel.out_sel[OUT_IRQ12];
        sel.alt_sel[ALT_CS2B_PAD]  = sel.slave & sel.cs2b_sel;
    end

    // R6
    cs2_src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.cs2a_sel, sel.cs2b_sel}));
endmodule

// File: rtl/hsd_gate.sv
module hsd_gate
    import hsd_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  hsd_sel_t           sel,
    input  logic               sd_act,
    input  logic [NUM_OUT-1:0] hp_out_o,
    input  logic [NUM_OUT-1:0] hp_out_oe,
    input  logic [DB_W-1:0]    hp_db_o,
    input  logic               hp_db_oe,
    output logic [NUM_OUT-1:0] pad_out_oe,
    output logic [NUM_OUT-1:0] pad_out_o,
    output logic [DB_W-1:0]    pad_db_oe,
    output logic [DB_W-1:0]    pad_db_o,
    input  hsd_ctl_t           pad_ctl,
    input  logic               pad_cs2a_n,
    input  logic [DB_W-1:0]    pad_db_i,
    input  logic [NUM_ALT-1:0] pad_shared_i,
    output hsd_ctl_t           hp_ctl,
    output logic               hp_cs2_n,
    output logic [DB_W-1:0]    hp_db_i,
    output logic [NUM_ALT-1:0] alt_in_o
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign pad_out_oe[i] = sel.out_sel[i] & ~sd_act & hp_out_oe[i];
        assign pad_out_o[i]  = hp_out_o[i];
    end

    for (genvar k = 0; k < NUM_ALT; k++) begin : g_alt
        assign alt_in_o[k] = hold_high(sel.alt_sel[k], sd_act, pad_shared_i[k]);
    end

    for (genvar b = 0; b < DB_W; b++) begin : g_db
        assign pad_db_oe[b] = sel.slave & ~sd_act & hp_db_oe;
        assign pad_db_o[b]  = hp_db_o[b];
        assign hp_db_i[b]   = hold_high(sel.slave, sd_act, pad_db_i[b]);
    end

    always_comb begin
        hp_ctl.cs1_n = hold_high(sel.slave, sd_act, pad_ctl.cs1_n);
        hp_ctl.rd_n  = hold_high(sel.slave, sd_act, pad_ctl.rd_n);
        hp_ctl.wr_n  = hold_high(sel.slave, sd_act, pad_ctl.wr_n);
        hp_ctl.a0    = hold_high(sel.slave, sd_act, pad_ctl.a0);
        if (sel.cs2a_sel)      hp_cs2_n = hold_high(1'b1, sd_act, pad_cs2a_n);
        else if (sel.cs2b_sel) hp_cs2_n = hold_high(1'b1, sd_act, pad_shared_i[ALT_CS2B_PAD]);
        else                   hp_cs2_n = 1'b1;
    end

    // R3
    out_oe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sd_act |-> (pad_out_oe == '0));
    // R3
    out_oe_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_out_oe & ~hp_out_oe) == '0);
    // R4
    db_oe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sd_act |-> (pad_db_oe == '0));
    // R5
    inputs_high_chk: assert property (@(posedge clk) disable iff (rst)
        sd_act |-> (hp_ctl.cs1_n & hp_ctl.rd_n & hp_ctl.wr_n & hp_ctl.a0 & (&hp_db_i) & hp_cs2_n));
endmodule

// File: rtl/hsd_top.sv
module hsd_top
    import hsd_pkg::*;
#(
    parameter int DB_W        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_single_chip,
    input  logic               cfg_host_en,
    input  logic               cfg_sd_en,
    input  logic               cfg_cs2_en,
    input  logic               cfg_ga20_en,
    input  logic [2:0]         cfg_dir,
    input  logic               sd_pad_n,
    input  logic [3:0]         hp_out_o,
    input  logic [3:0]         hp_out_oe,
    input  logic [DB_W-1:0]    hp_db_o,
    input  logic               hp_db_oe,
    output logic [3:0]         pad_out_oe,
    output logic [3:0]         pad_out_o,
    output logic [DB_W-1:0]    pad_db_oe,
    output logic [DB_W-1:0]    pad_db_o,
    input  logic               pad_cs1_n,
    input  logic               pad_cs2a_n,
    input  logic               pad_rd_n,
    input  logic               pad_wr_n,
    input  logic               pad_a0,
    input  logic [DB_W-1:0]    pad_db_i,
    input  logic [2:0]         pad_shared_i,
    output logic               hp_cs1_n,
    output logic               hp_cs2_n,
    output logic               hp_rd_n,
    output logic               hp_wr_n,
    output logic               hp_a0,
    output logic [DB_W-1:0]    hp_db_i,
    output logic [2:0]         alt_in_o
);
    hsd_cfg_t cfg;
    hsd_sel_t sel;
    hsd_ctl_t pad_ctl;
    hsd_ctl_t hp_ctl;
    logic     pad_low_q;
    logic     sd_act;

    assign cfg = '{single_chip: cfg_single_chip, host_en: cfg_host_en, sd_en: cfg_sd_en,
                   cs2_en: cfg_cs2_en, ga20_en: cfg_ga20_en, dir: cfg_dir};
    assign pad_ctl = '{cs1_n: pad_cs1_n, rd_n: pad_rd_n, wr_n: pad_wr_n, a0: pad_a0};

    hsd_sync #(.SYNC_STAGES(SYNC_STAGES), .HOLD_STAGES(HOLD_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pad_n(sd_pad_n), .low_q(pad_low_q));

    hsd_select u_sel (.clk(clk), .rst(rst), .cfg(cfg), .sel(sel));

    assign sd_act = sel.sd_allowed & pad_low_q;

    hsd_gate #(.DB_W(DB_W)) u_gate (
        .clk(clk), .rst(rst), .sel(sel), .sd_act(sd_act),
        .hp_out_o(hp_out_o), .hp_out_oe(hp_out_oe), .hp_db_o(hp_db_o), .hp_db_oe(hp_db_oe),
        .pad_out_oe(pad_out_oe), .pad_out_o(pad_out_o), .pad_db_oe(pad_db_oe), .pad_db_o(pad_db_o),
        .pad_ctl(pad_ctl), .pad_cs2a_n(pad_cs2a_n), .pad_db_i(pad_db_i), .pad_shared_i(pad_shared_i),
        .hp_ctl(hp_ctl), .hp_cs2_n(hp_cs2_n), .hp_db_i(hp_db_i), .alt_in_o(alt_in_o));

    assign hp_cs1_n = hp_ctl.cs1_n;
    assign hp_rd_n  = hp_ctl.rd_n;
    assign hp_wr_n  = hp_ctl.wr_n;
    assign hp_a0    = hp_ctl.a0;

    // R1
    sd_gated_off_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_single_chip && cfg_host_en && cfg_sd_en) |-> (pad_out_oe == (hp_out_oe & sel.out_sel)));
    // R6
    cs2_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_cs2_en |-> hp_cs2_n);
    // R9
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !sd_act);
endmodule

// File: tb/hsd_top_tb.sv
module hsd_top_tb;
    localparam int DB_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_single_chip, cfg_host_en, cfg_sd_en, cfg_cs2_en, cfg_ga20_en;
    logic [2:0] cfg_dir;
    logic sd_pad_n;
    logic [3:0] hp_out_o, hp_out_oe;
    logic [DB_W-1:0] hp_db_o;
    logic hp_db_oe;
    logic [3:0] pad_out_oe, pad_out_o;
    logic [DB_W-1:0] pad_db_oe, pad_db_o;
    logic pad_cs1_n, pad_cs2a_n, pad_rd_n, pad_wr_n, pad_a0;
    logic [DB_W-1:0] pad_db_i;
    logic [2:0] pad_shared_i;
    logic hp_cs1_n, hp_cs2_n, hp_rd_n, hp_wr_n, hp_a0;
    logic [DB_W-1:0] hp_db_i;
    logic [2:0] alt_in_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hsd_top #(.DB_W(DB_W)) u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] exp_sel();
        logic s;
        s = cfg_single_chip & cfg_host_en;
        return {s & cfg_ga20_en, s & cfg_dir[2], s & cfg_cs2_en & cfg_dir[1], s & cfg_dir[0]};
    endfunction

    task automatic cfg_full();
        cfg_single_chip = 1; cfg_host_en = 1; cfg_sd_en = 1;
        cfg_cs2_en = 1; cfg_ga20_en = 1; cfg_dir = 3'b111;
        hp_out_oe = 4'hF; hp_db_oe = 1;
    endtask

    task automatic t_reset();
        // R9
        check("R9 out_oe", pad_out_oe, 4'hF);
        check("R9 db_oe", pad_db_oe, 8'hFF);
    endtask

    task automatic t_latency();
        sd_pad_n = 0;
        step(3);
        check("R2 db_oe after 3", pad_db_oe, 8'hFF);
        step(1);
        check("R2 db_oe after 4", pad_db_oe, 8'h00);
        check("R2 out_oe after 4", pad_out_oe, 4'h0);
        sd_pad_n = 1;
        step(3);
        check("R10 out_oe after 3", pad_out_oe, 4'h0);
        step(1);
        check("R10 out_oe after 4", pad_out_oe, 4'hF);
        check("R10 db_oe after 4", pad_db_oe, 8'hFF);
    endtask

    task automatic t_outputs();
        for (int c = 0; c < 32; c++) begin
            cfg_dir = c[2:0]; cfg_cs2_en = c[3]; cfg_ga20_en = c[4];
            hp_out_oe = 4'(c * 7 + 5);
            #1;
            // R3
            check("R3 selection", pad_out_oe, exp_sel() & hp_out_oe);
        end
        cfg_full();
        hp_out_oe = 4'b0101;
        sd_pad_n = 0; step(4);
        check("R3 shutdown partial", pad_out_oe, 4'h0);
        sd_pad_n = 1; step(4);
        check("R3 partial restored", pad_out_oe, 4'b0101);
        cfg_full();
    endtask

    task automatic t_inputs();
        pad_cs1_n = 0; pad_rd_n = 0; pad_wr_n = 0; pad_a0 = 0; pad_db_i = 8'h3C;
        #1;
        check("R5 pass", {hp_cs1_n, hp_rd_n, hp_wr_n, hp_a0, hp_db_i}, {4'b0000, 8'h3C});
        sd_pad_n = 0; step(4);
        check("R5 forced", {hp_cs1_n, hp_rd_n, hp_wr_n, hp_a0, hp_db_i}, {4'b1111, 8'hFF});
        sd_pad_n = 1; step(4);
        check("R5 released", {hp_cs1_n, hp_rd_n, hp_wr_n, hp_a0, hp_db_i}, {4'b0000, 8'h3C});
    endtask

    task automatic t_cs2();
        pad_cs2a_n = 0; pad_shared_i = 3'b011;
        cfg_cs2_en = 1; cfg_ga20_en = 0; #1;
        check("R6 from shared-ga20 pad", hp_cs2_n, 1'b0);
        pad_cs2a_n = 1; pad_shared_i = 3'b000; #1;
        check("R6 shared-ga20 pad high", hp_cs2_n, 1'b1);
        cfg_ga20_en = 1; #1;
        check("R6 from alternate pad", hp_cs2_n, 1'b0);
        cfg_cs2_en = 0; #1;
        check("R6 disabled", hp_cs2_n, 1'b1);
        cfg_cs2_en = 1; cfg_ga20_en = 0; pad_cs2a_n = 0;
        sd_pad_n = 0; step(4);
        check("R6 forced in shutdown", hp_cs2_n, 1'b1);
        sd_pad_n = 1; step(4);
        check("R6 restored", hp_cs2_n, 1'b0);
        cfg_full();
    endtask

    task automatic t_alt();
        pad_shared_i = 3'b000;
        cfg_cs2_en = 1; cfg_ga20_en = 0; cfg_dir = 3'b010;
        sd_pad_n = 0; step(4);
        // R7: only pad 0 host-selected
        check("R7 partial select", alt_in_o, 3'b001);
        cfg_dir = 3'b110; cfg_ga20_en = 1; #1;
        check("R7 all selected", alt_in_o, 3'b111);
        cfg_cs2_en = 0; cfg_dir = 3'b000; #1;
        check("R7 none selected", alt_in_o, 3'b000);
        sd_pad_n = 1; step(4);
        cfg_full(); #1;
        check("R7 no shutdown", alt_in_o, 3'b000);
    endtask

    task automatic t_disabled();
        cfg_sd_en = 0;
        sd_pad_n = 0; step(6);
        check("R1 sd_en off out", pad_out_oe, 4'hF);
        check("R1 sd_en off db", pad_db_oe, 8'hFF);
        cfg_sd_en = 1; cfg_host_en = 0; pad_a0 = 0; pad_shared_i = 3'b000; #1;
        check("R1 not slave out", pad_out_oe, 4'h0);
        check("R1 not slave input", {hp_a0, alt_in_o}, 4'b0000);
        cfg_host_en = 1; cfg_single_chip = 0; #1;
        check("R1 not single-chip", {hp_a0, alt_in_o}, 4'b0000);
        cfg_single_chip = 1; #1;
        check("R1 slave restored", {hp_a0, pad_db_oe}, {1'b1, 8'h00});
        sd_pad_n = 1; step(4);
        cfg_full();
    endtask

    task automatic t_data();
        hp_out_o = 4'b1010; hp_db_o = 8'h5A; #1;
        check("R8 out values", pad_out_o, 4'b1010);
        check("R8 db values", pad_db_o, 8'h5A);
        sd_pad_n = 0; step(4);
        hp_out_o = 4'b0110; hp_db_o = 8'hC3; #1;
        check("R8 values in shutdown", {pad_out_o, pad_db_o}, {4'b0110, 8'hC3});
        sd_pad_n = 1; step(4);
    endtask

    initial begin
        cfg_full();
        sd_pad_n = 1; hp_out_o = 0; hp_db_o = 0;
        pad_cs1_n = 1; pad_cs2a_n = 1; pad_rd_n = 1; pad_wr_n = 1; pad_a0 = 1;
        pad_db_i = 0; pad_shared_i = 0;
        step(3);
        rst = 0;
        step(1);
        t_reset();
        t_latency();
        t_outputs();
        t_inputs();
        t_cs2();
        t_alt();
        t_disabled();
        t_data();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule